// File: doc/BRIEF.md
# Double-Buffered IN Transmit Arbiter

This block decides which of two transmit buffers, called A and B, serves a device-side bulk IN endpoint. Software first writes a byte count for a buffer and then arms that buffer by pulsing its load bit. When the host side asks for data, the arbiter picks an armed buffer and passes that buffer's base address and length to a downstream packet sender. When the sender reports an acknowledged completion, the arbiter clears the buffer's load bit. If no permitted buffer is armed, the block answers with a NAK. The sender itself, the buffer RAM and the host-side protocol are outside this block. A one-cycle request pulse and a one-cycle done pulse stand in for the host side.

Buffer A always wins when it is armed. Buffer B is used only when double buffering is enabled and A is not armed. A transmit-active status is high while any buffer is armed. A sticky interrupt flag is set when that status falls, so a handler can rearm buffers without polling.

Top module: `txbuf_arbiter`

## Requirements
- R1: After reset `load_q` is 00, and `tx_active`, `tx_irq`, `snd_start` and `host_nak` are all 0.
- R2: A write with `cnt_wr`=1 stores `cnt_wdata` into the count of the buffer chosen by `cnt_sel` (0 = A, 1 = B). When a buffer is granted, `snd_len` carries its stored count, which may be 0. `snd_addr` carries `BASE_A` for A and `BASE_B` for B.
- R3: A pulse on `load_set[0]` (A) or `load_set[1]` (B) sets the matching `load_q` bit in the next cycle. The bit stays set until that buffer is sent with an acknowledge. `tx_active` is the OR of both `load_q` bits.
- R4: If `load_q[0]` is set when an accepted request arrives, buffer A is granted (`snd_sel`=0), whatever the state of B.
- R5: Buffer B is granted (`snd_sel`=1) only when `dbl_en`=1, `load_q[1]`=1 and `load_q[0]`=0 at the request.
- R6: A request with no permitted buffer armed produces a one-cycle `host_nak` pulse in the next cycle. It produces no `snd_start` and does not change `load_q`.
- R7: `snd_done` together with `snd_ack`=1 clears the in-flight buffer's `load_q` bit in the next cycle. `snd_done` with `snd_ack`=0 leaves that bit set, so the buffer can be granted again.
- R8: A count write to a buffer whose `load_q` bit is set is ignored.
- R9: `tx_irq` goes to 1 in the cycle after `tx_active` falls and stays set until `irq_clr`=1. If a set and a clear happen in the same cycle, the set wins.
- R10: `snd_start` is a one-cycle pulse in the cycle after an accepted request. `snd_sel`, `snd_addr` and `snd_len` stay stable until `snd_done`. Requests that arrive while a send is in flight are ignored, with no NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbl_en | input | 1 | Double buffering enable; allows buffer B to be used |
| cnt_wr | input | 1 | Byte-count write strobe |
| cnt_sel | input | 1 | Count write target: 0 = A, 1 = B |
| cnt_wdata | input | CNT_W | Byte count to write |
| load_set | input | 2 | Arm pulse; bit 0 = A, bit 1 = B |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| host_req | input | 1 | Host data request pulse |
| host_nak | output | 1 | NAK response pulse |
| snd_start | output | 1 | Start pulse to the packet sender |
| snd_sel | output | 1 | Buffer being sent: 0 = A, 1 = B |
| snd_addr | output | ADDR_W | Base address of the buffer being sent |
| snd_len | output | CNT_W | Byte count of the buffer being sent |
| snd_done | input | 1 | Sender completion pulse |
| snd_ack | input | 1 | Completion was acknowledged; valid with snd_done |
| load_q | output | 2 | Load bits; bit 0 = A, bit 1 = B |
| tx_active | output | 1 | High while any buffer is armed |
| tx_irq | output | 1 | Sticky flag, set on a falling edge of tx_active |

## Verification
The bench sweeps all eight combinations of the double-buffer enable and the two load bits, using three count pairs that include 0 and the maximum count. For each combination it checks the grant or the NAK. A design that let B win over an armed A, or used B while double buffering was off, would show the wrong `snd_sel` and address. A design that disturbed state on a NAK would show changed load bits.

Separate sequences cover the following cases:
- A count write while the buffer is armed. A design that does not lock the count would send the new length.
- A completion without an acknowledge. A design that clears the load bit anyway would lose the retry.
- A request while a send is in flight. A design that accepts it would produce a second start pulse or a NAK.
- The interrupt flag, checked for its one-cycle latency after the active status falls, for staying set, and for a set winning over a clear in the same cycle. A design that fires on the rising edge, or drops the flag, fails these checks.

// File: rtl/txarb_pkg.sv
// Package: shared types for the double-buffered IN transmit arbiter.
// Assumes exactly two buffers, A (index 0) and B (index 1).
package txarb_pkg;
    localparam int NBUF = 2;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } buf_sel_e;
endpackage

// File: rtl/txarb_cnt_regs.sv
// Module: per-buffer byte-count registers.
// A write lands only when the target buffer is not armed. Assumes the load
// bits come from txarb_load_ctl.
module txarb_cnt_regs
    import txarb_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  buf_sel_e                   wr_sel,
    input  logic [CNT_W-1:0]           wr_data,
    input  logic [NBUF-1:0]            load_i,
    output logic [NBUF-1:0][CNT_W-1:0] cnt_o
);
    for (genvar i = 0; i < NBUF; i++) begin : g_cnt
        // Store a count write when this buffer is addressed and not locked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_o[i] <= '0;
            end else if (wr_en && (int'(wr_sel) == i) && !load_i[i]) begin
                cnt_o[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/txarb_load_ctl.sv
// Module: load bits of both buffers.
// A set pulse arms a buffer. A clear (acknowledged send) disarms it, and the
// clear wins over a set in the same cycle.
module txarb_load_ctl
    import txarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_i,
    input  logic [NBUF-1:0] clr_i,
    output logic [NBUF-1:0] load_o
);
    for (genvar i = 0; i < NBUF; i++) begin : g_load
        // Update one load bit; the clear takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                load_o[i] <= 1'b0;
            end else if (clr_i[i]) begin
                load_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                load_o[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txarb_pick.sv
// Module: combinational buffer choice.
// A wins whenever it is armed. B is eligible only with double buffering on.
// Assumes the caller qualifies the result with an accepted request.
module txarb_pick
    import txarb_pkg::*;
(
    input  logic [NBUF-1:0] load_i,
    input  logic            dbl_en_i,
    output logic            grant_o,
    output buf_sel_e        grant_sel_o
);
    // Priority choice between the two buffers.
    always_comb begin
        grant_o     = 1'b0;
        grant_sel_o = SEL_A;
        if (load_i[0]) begin
            grant_o     = 1'b1;
            grant_sel_o = SEL_A;
        end else if (dbl_en_i && load_i[1]) begin
            grant_o     = 1'b1;
            grant_sel_o = SEL_B;
        end
    end
endmodule

// File: rtl/txarb_irq.sv
// Module: falling-edge detector with a sticky, write-1-clear flag.
// Assumes active_i is a registered level. The flag appears one cycle after
// the fall, and a set beats a clear.
module txarb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic clr_i,
    output logic irq_o
);
    logic active_q;

    // Remember last cycle's active level.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_i;
    end

    // Set on a fall, otherwise clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (active_q && !active_i) begin
            irq_o <= 1'b1;
        end else if (clr_i) begin
            irq_o <= 1'b0;
        end
    end
endmodule

// File: rtl/txbuf_arbiter.sv
// Module: top of the double-buffered IN transmit arbiter.
// On a host request it grants an armed buffer to the packet sender, or it
// answers with a NAK. An acknowledged completion disarms the sent buffer.
// Assumes the sender raises snd_done exactly once per snd_start.
module txbuf_arbiter
    import txarb_pkg::*;
#(
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned BASE_A = 0,
    parameter int unsigned BASE_B = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_en,
    input  logic              cnt_wr,
    input  logic              cnt_sel,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [1:0]        load_set,
    input  logic              irq_clr,
    input  logic              host_req,
    output logic              host_nak,
    output logic              snd_start,
    output logic              snd_sel,
    output logic [ADDR_W-1:0] snd_addr,
    output logic [CNT_W-1:0]  snd_len,
    input  logic              snd_done,
    input  logic              snd_ack,
    output logic [1:0]        load_q,
    output logic              tx_active,
    output logic              tx_irq
);
    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(BASE_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(BASE_B);

    logic                       busy;
    buf_sel_e                   cur_sel;
    logic                       grant;
    buf_sel_e                   grant_sel;
    logic [NBUF-1:0]            load_clr;
    logic [NBUF-1:0][CNT_W-1:0] cnt_q;
    logic                       accept;

    txarb_cnt_regs #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr),
        .wr_sel  (buf_sel_e'(cnt_sel)),
        .wr_data (cnt_wdata),
        .load_i  (load_q),
        .cnt_o   (cnt_q)
    );

    txarb_load_ctl u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (load_set),
        .clr_i  (load_clr),
        .load_o (load_q)
    );

    txarb_pick u_pick (
        .load_i      (load_q),
        .dbl_en_i    (dbl_en),
        .grant_o     (grant),
        .grant_sel_o (grant_sel)
    );

    txarb_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (tx_active),
        .clr_i    (irq_clr),
        .irq_o    (tx_irq)
    );

    // Active status: any buffer armed.
    assign tx_active = |load_q;
    assign accept    = host_req && !busy;
    assign snd_sel   = logic'(cur_sel);

    // Disarm the in-flight buffer on an acknowledged completion.
    always_comb begin
        load_clr = '0;
        if (busy && snd_done && snd_ack) begin
            load_clr[cur_sel] = 1'b1;
        end
    end

    // Request handling: grant, NAK, and completion of the in-flight send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cur_sel   <= SEL_A;
            snd_start <= 1'b0;
            host_nak  <= 1'b0;
            snd_addr  <= '0;
            snd_len   <= '0;
        end else begin
            snd_start <= 1'b0;
            host_nak  <= 1'b0;
            if (accept) begin
                if (grant) begin
                    busy      <= 1'b1;
                    cur_sel   <= grant_sel;
                    snd_start <= 1'b1;
                    snd_len   <= cnt_q[grant_sel];
                    snd_addr  <= (grant_sel == SEL_B) ? ADDR_B : ADDR_A;
                end else begin
                    host_nak  <= 1'b1;
                end
            end else if (busy && snd_done) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/txarb_chk.sv
// Module: assertion checker for txbuf_arbiter, attached with bind.
// Assumes the internal busy flag, in-flight selection and count registers
// are connected by the bind below.
module txarb_chk #(
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbl_en,
    input logic              host_req,
    input logic              host_nak,
    input logic              snd_start,
    input logic              snd_sel,
    input logic [ADDR_W-1:0] snd_addr,
    input logic [CNT_W-1:0]  snd_len,
    input logic              snd_done,
    input logic              snd_ack,
    input logic [1:0]        load_q,
    input logic              tx_active,
    input logic              tx_irq,
    input logic              busy,
    input logic              cur_sel,
    input logic [CNT_W-1:0]  cnt_a,
    input logic [CNT_W-1:0]  cnt_b
);
    AST_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !busy && load_q[0]) |=> (snd_start && !snd_sel)); // R4
    AST_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_start && snd_sel) |-> ($past(dbl_en) && $past(load_q[1]) && !$past(load_q[0]))); // R5
    AST_NAK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        host_nak |-> (!$past(load_q[0]) && !($past(dbl_en) && $past(load_q[1])))); // R6
    AST_NAK_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !busy && !load_q[0] && !(dbl_en && load_q[1])) |=> (!snd_start && !busy)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && snd_done && snd_ack) |=> !load_q[$past(cur_sel)]); // R7
    AST_CNT_LOCK_A: assert property (@(posedge clk) disable iff (!rst_n)
        load_q[0] |=> $stable(cnt_a)); // R8
    AST_CNT_LOCK_B: assert property (@(posedge clk) disable iff (!rst_n)
        load_q[1] |=> $stable(cnt_b)); // R8
    AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |=> tx_irq); // R9
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        snd_start |=> !snd_start); // R10
    AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !snd_done) |=> ($stable(snd_len) && $stable(snd_addr) && $stable(snd_sel))); // R10
endmodule

bind txbuf_arbiter txarb_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl_en    (dbl_en),
    .host_req  (host_req),
    .host_nak  (host_nak),
    .snd_start (snd_start),
    .snd_sel   (snd_sel),
    .snd_addr  (snd_addr),
    .snd_len   (snd_len),
    .snd_done  (snd_done),
    .snd_ack   (snd_ack),
    .load_q    (load_q),
    .tx_active (tx_active),
    .tx_irq    (tx_irq),
    .busy      (busy),
    .cur_sel   (cur_sel),
    .cnt_a     (cnt_q[0]),
    .cnt_b     (cnt_q[1])
);

// File: tb/txbuf_arbiter_tb.sv
// Bench: sweeps all enable/load combinations over several count pairs, then
// runs directed sequences for locking, retry, busy requests and the interrupt.
module txbuf_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 7;
    localparam int ADDR_W     = 9;
    localparam int BASE_A     = 0;
    localparam int BASE_B     = 64;
    localparam int MAXC       = (1 << CNT_W) - 1;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dbl_en = 1'b0;
    logic              cnt_wr = 1'b0;
    logic              cnt_sel = 1'b0;
    logic [CNT_W-1:0]  cnt_wdata = '0;
    logic [1:0]        load_set = '0;
    logic              irq_clr = 1'b0;
    logic              host_req = 1'b0;
    logic              host_nak;
    logic              snd_start;
    logic              snd_sel;
    logic [ADDR_W-1:0] snd_addr;
    logic [CNT_W-1:0]  snd_len;
    logic              snd_done = 1'b0;
    logic              snd_ack = 1'b0;
    logic [1:0]        load_q;
    logic              tx_active;
    logic              tx_irq;

    int  checks = 0;
    int  errs   = 0;
    bit  fin    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txbuf_arbiter #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .dbl_en(dbl_en), .cnt_wr(cnt_wr),
        .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata), .load_set(load_set),
        .irq_clr(irq_clr), .host_req(host_req), .host_nak(host_nak),
        .snd_start(snd_start), .snd_sel(snd_sel), .snd_addr(snd_addr),
        .snd_len(snd_len), .snd_done(snd_done), .snd_ack(snd_ack),
        .load_q(load_q), .tx_active(tx_active), .tx_irq(tx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_cnt(input bit sel, input int val);
        cnt_wr = 1'b1; cnt_sel = sel; cnt_wdata = CNT_W'(val);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic arm(input logic [1:0] m);
        load_set = m;
        @(negedge clk);
        load_set = '0;
    endtask

    task automatic req();
        host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic done(input bit ack);
        snd_done = 1'b1; snd_ack = ack;
        @(negedge clk);
        snd_done = 1'b0; snd_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!fin) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int va, vb, exp_sel, rem;
        bit la, lb, dbl;
        do_reset();
        chk("R1 load_q", int'(load_q), 0);
        chk("R1 tx_active", int'(tx_active), 0);
        chk("R1 tx_irq", int'(tx_irq), 0);
        chk("R1 snd_start", int'(snd_start), 0);
        chk("R1 host_nak", int'(host_nak), 0);

        // Sweep: 3 count pairs x {dbl_en, load B, load A}.
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 8; m++) begin
                va  = (p == 0) ? 0 : (p == 1) ? 5 : MAXC;
                vb  = (p == 0) ? MAXC : (p == 1) ? 0 : 17;
                la  = m[0]; lb = m[1]; dbl = m[2];
                do_reset();
                wr_cnt(1'b0, va);
                wr_cnt(1'b1, vb);
                dbl_en = dbl;
                arm({lb, la});
                chk("R3 load_q after arm", int'(load_q), m & 3);
                chk("R3 tx_active", int'(tx_active), int'(la | lb));
                exp_sel = la ? 0 : (dbl && lb) ? 1 : -1;
                req();
                if (exp_sel < 0) begin
                    chk("R6 host_nak", int'(host_nak), 1);
                    chk("R6 no snd_start", int'(snd_start), 0);
                    chk("R6 load_q unchanged", int'(load_q), m & 3);
                    @(negedge clk);
                    chk("R6 nak one cycle", int'(host_nak), 0);
                end else begin
                    chk("R10 snd_start", int'(snd_start), 1);
                    chk("R4 R5 snd_sel", int'(snd_sel), exp_sel);
                    chk("R2 snd_len", int'(snd_len), exp_sel ? vb : va);
                    chk("R2 snd_addr", int'(snd_addr), exp_sel ? BASE_B : BASE_A);
                    chk("R6 no nak on grant", int'(host_nak), 0);
                    done(1'b1);
                    rem = (m & 3) & ~(1 << exp_sel);
                    chk("R7 load cleared", int'(load_q), rem);
                    chk("R3 tx_active after send", int'(tx_active), int'(rem != 0));
                    @(negedge clk);
                    chk("R9 irq after fall", int'(tx_irq), int'(rem == 0));
                end
            end
        end

        // R8: a count write while armed is ignored.
        do_reset();
        dbl_en = 1'b0;
        wr_cnt(1'b0, 10);
        arm(2'b01);
        wr_cnt(1'b0, 99);
        req();
        chk("R8 locked count", int'(snd_len), 10);
        // R10: a request while busy is ignored.
        req();
        chk("R10 no restart while busy", int'(snd_start), 0);
        chk("R10 no nak while busy", int'(host_nak), 0);
        chk("R10 len held", int'(snd_len), 10);
        // R7: a completion without ack keeps the buffer armed.
        done(1'b0);
        chk("R7 nack keeps load", int'(load_q), 1);
        req();
        chk("R7 retry start", int'(snd_start), 1);
        chk("R7 retry sel A", int'(snd_sel), 0);
        done(1'b1);
        chk("R7 ack clears", int'(load_q), 0);
        @(negedge clk);
        chk("R9 irq set", int'(tx_irq), 1);
        repeat (3) @(negedge clk);
        chk("R9 irq sticky", int'(tx_irq), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R9 irq cleared", int'(tx_irq), 0);
        wr_cnt(1'b0, 99);
        arm(2'b01);
        req();
        chk("R8 unlocked count", int'(snd_len), 99);

        // R9: a set wins over a clear in the same cycle.
        done(1'b1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R9 set beats clear", int'(tx_irq), 1);

        // R4/R5: both armed with double buffering on; A first, then B.
        do_reset();
        dbl_en = 1'b1;
        wr_cnt(1'b0, 3);
        wr_cnt(1'b1, 4);
        arm(2'b11);
        req();
        chk("R4 A before B", int'(snd_sel), 0);
        done(1'b1);
        chk("R3 B still armed", int'(load_q), 2);
        @(negedge clk);
        chk("R9 no irq while active", int'(tx_irq), 0);
        req();
        chk("R5 B next", int'(snd_sel), 1);
        chk("R2 B len", int'(snd_len), 4);
        done(1'b1);
        @(negedge clk);
        chk("R9 irq after both", int'(tx_irq), 1);

        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule